// File: doc/BRIEF.md
# Memory Operation Pair Ordering Checker

This block decides whether two memory operations from the same hardware thread must keep their program order in the global memory order under a weak memory model. The older operation is called A and the younger B. Each is described by its kind (load, store, or atomic read-modify-write, which counts as both), its byte address and size, its acquire/release annotation bits, a flag that makes those annotations sequentially-consistent, a flag for regular main memory as opposed to I/O space, and a flag for A being produced by an atomic or store-conditional.

A dependency tracker supplies the rest as single-bit inputs. These cover: address, data and control dependencies of B on A; an intervening fence with its predecessor and successor masks; whether A and B form a reserve/conditional pair; and value-source facts that describe which write each load returned. The block is pulsed with a valid strobe. One cycle later it gives a must-order bit and a 4-bit reason code. The code names the lowest-numbered rule that matched.

Top module: `ppo_pair_checker`

## Requirements
- R1: If either A or B is marked as not being regular main memory, the result is "no order" with reason 0, whatever the other inputs are.
- R2: Kinds are encoded 00 load, 01 store, 10 atomic. Sizes are encoded 0..3 for 1, 2, 4 and 8 bytes. If B writes memory (store or atomic) and the byte ranges of A and B overlap inside the same aligned 8-byte window, the pair is ordered with reason 1.
- R3: An access whose byte range runs past the end of its aligned 8-byte window counts as overlapping any other access.
- R4: If A comes from an atomic or store-conditional, B reads memory and B returned the value A wrote, the pair is ordered with reason 2.
- R5: If A and B both read, their byte ranges overlap and the different-writer flag is set, the pair is ordered with reason 3. With no overlap, that flag has no effect.
- R6: The fence masks use bit 1 for reads and bit 0 for writes. An intervening fence orders the pair with reason 4 when A's kind meets a set predecessor bit and B's kind meets a set successor bit.
- R7: An acquire bit on A orders the pair with reason 5. A release bit on B orders it with reason 6.
- R8: If both A and B carry at least one annotation bit and both are flagged sequentially-consistent, the reason is 7. A reserve/conditional pairing gives reason 8.
- R9: An address dependency gives reason 9. A data dependency gives reason 10 and a control dependency gives reason 11, but these two count only when B writes memory.
- R10: If B reads and returned a value from an intervening store that depended on A, the reason is 12. If B writes and an intervening instruction has an address dependency on A, the reason is 13.
- R11: When several rules match, the reason code is the lowest-numbered matching one.
- R12: Outputs are zero after reset. The done flag is high exactly in the cycle after a valid strobe. The order bit and reason are registered from the inputs of that strobe and hold while valid stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Evaluate the presented pair |
| a_kind_i | input | 2 | Kind of A |
| a_addr_i | input | ADDR_W | Byte address of A |
| a_size_i | input | SIZE_W | log2 of A's size in bytes |
| a_aq_i | input | 1 | A has acquire annotation |
| a_rl_i | input | 1 | A has release annotation |
| a_sc_ann_i | input | 1 | A's annotations are sequentially-consistent |
| a_main_i | input | 1 | A targets regular main memory |
| a_atomic_src_i | input | 1 | A came from an atomic or store-conditional |
| b_kind_i | input | 2 | Kind of B |
| b_addr_i | input | ADDR_W | Byte address of B |
| b_size_i | input | SIZE_W | log2 of B's size in bytes |
| b_aq_i | input | 1 | B has acquire annotation |
| b_rl_i | input | 1 | B has release annotation |
| b_sc_ann_i | input | 1 | B's annotations are sequentially-consistent |
| b_main_i | input | 1 | B targets regular main memory |
| fence_i | input | 1 | A fence lies between A and B |
| fence_pred_i | input | 2 | Fence predecessor mask (read, write) |
| fence_succ_i | input | 2 | Fence successor mask (read, write) |
| paired_i | input | 1 | A and B are a reserve/conditional pair |
| dep_addr_i | input | 1 | B's address depends on A |
| dep_data_i | input | 1 | B's store data depends on A |
| dep_ctrl_i | input | 1 | A branch between them depends on A |
| b_got_a_i | input | 1 | B returned the value A wrote |
| ld_diff_src_i | input | 1 | Shared bytes came from different writers |
| fwd_dep_store_i | input | 1 | B returned a value from a store dependent on A |
| mid_addr_dep_i | input | 1 | An intervening instruction has an address dependency on A |
| done_o | output | 1 | Result valid this cycle |
| order_o | output | 1 | B must stay ordered after A |
| reason_o | output | 4 | First matching rule, 0 if none |

## Verification
A wrong byte mask or window compare would first show as an order bit that is set or cleared in error for partly overlapping or window-crossing pairs. It would appear on the outputs one cycle after the strobe. A broken priority would leave the order bit correct and give a wrong reason code, so every check compares both. A stale result register would show up as a changed reason while valid is low, or as a missing done pulse. Random pairs are drawn from a small address range so that overlaps and stacked rules occur often.

// File: rtl/ppo_pkg.sv
package ppo_pkg;
   typedef enum logic [1:0] {
      K_LOAD  = 2'b00,
      K_STORE = 2'b01,
      K_AMO   = 2'b10,
      K_NONE  = 2'b11
   } mem_kind_e;

   localparam int NUM_RULES = 13;
   localparam int CODE_W    = 4;

   // rule index i reports reason code i+1
   localparam int RI_OVL_ST   = 0;
   localparam int RI_ATOM_FWD = 1;
   localparam int RI_LD_LD    = 2;
   localparam int RI_FENCE    = 3;
   localparam int RI_ACQ      = 4;
   localparam int RI_REL      = 5;
   localparam int RI_SC_BOTH  = 6;
   localparam int RI_PAIRED   = 7;
   localparam int RI_DEP_ADDR = 8;
   localparam int RI_DEP_DATA = 9;
   localparam int RI_DEP_CTRL = 10;
   localparam int RI_PIPE_FWD = 11;
   localparam int RI_PIPE_ADR = 12;

   function automatic logic kind_reads(input logic [1:0] k);
      return (k == K_LOAD) || (k == K_AMO);
   endfunction

   function automatic logic kind_writes(input logic [1:0] k);
      return (k == K_STORE) || (k == K_AMO);
   endfunction
endpackage

// File: rtl/ppo_overlap.sv
module ppo_overlap #(
   parameter int ADDR_W    = 32,
   parameter int SIZE_W    = 2,
   parameter int WIN_BYTES = 8
) (
   input  logic [ADDR_W-1:0] a_addr_i,
   input  logic [SIZE_W-1:0] a_size_i,
   input  logic [ADDR_W-1:0] b_addr_i,
   input  logic [SIZE_W-1:0] b_size_i,
   output logic              overlap_o
);
   localparam int OFS_W = $clog2(WIN_BYTES);
   localparam int LEN_W = OFS_W + 2;

   initial begin
      assert (WIN_BYTES >= 2 && (WIN_BYTES & (WIN_BYTES - 1)) == 0)
         else $error("WIN_BYTES must be a power of two");
      assert ((1 << ((1 << SIZE_W) - 1)) <= WIN_BYTES)
         else $error("largest access exceeds the window");
   end

   logic [LEN_W-1:0]     a_ofs, b_ofs, a_end, b_end;
   logic [WIN_BYTES-1:0] a_mask, b_mask;
   logic                 a_cross, b_cross, same_win;

   assign a_ofs    = LEN_W'(a_addr_i[OFS_W-1:0]);
   assign b_ofs    = LEN_W'(b_addr_i[OFS_W-1:0]);
   assign a_end    = a_ofs + (LEN_W'(1) << a_size_i);
   assign b_end    = b_ofs + (LEN_W'(1) << b_size_i);
   assign a_cross  = a_end > LEN_W'(WIN_BYTES);
   assign b_cross  = b_end > LEN_W'(WIN_BYTES);
   assign same_win = a_addr_i[ADDR_W-1:OFS_W] == b_addr_i[ADDR_W-1:OFS_W];

   for (genvar k = 0; k < WIN_BYTES; k++) begin : g_lane
      assign a_mask[k] = (LEN_W'(k) >= a_ofs) && (LEN_W'(k) < a_end);
      assign b_mask[k] = (LEN_W'(k) >= b_ofs) && (LEN_W'(k) < b_end);
   end

   assign overlap_o = a_cross || b_cross || (same_win && |(a_mask & b_mask));

   // R2: identical base addresses always share their first byte
   always_comb begin
      if (a_addr_i == b_addr_i)
         p_same_base_overlaps_r2 : assert (overlap_o);
   end
endmodule

// File: rtl/ppo_rules.sv
module ppo_rules
   import ppo_pkg::*;
(
   input  logic [1:0] a_kind_i,
   input  logic [1:0] b_kind_i,
   input  logic       overlap_i,
   input  logic       both_main_i,
   input  logic       a_aq_i,
   input  logic       a_rl_i,
   input  logic       a_sc_ann_i,
   input  logic       a_atomic_src_i,
   input  logic       b_aq_i,
   input  logic       b_rl_i,
   input  logic       b_sc_ann_i,
   input  logic       fence_i,
   input  logic [1:0] fence_pred_i,
   input  logic [1:0] fence_succ_i,
   input  logic       paired_i,
   input  logic       dep_addr_i,
   input  logic       dep_data_i,
   input  logic       dep_ctrl_i,
   input  logic       b_got_a_i,
   input  logic       ld_diff_src_i,
   input  logic       fwd_dep_store_i,
   input  logic       mid_addr_dep_i,
   output logic [NUM_RULES-1:0] hit_o
);
   logic a_rd, a_wr, b_rd, b_wr, fence_hit;
   logic [NUM_RULES-1:0] raw;

   assign a_rd = kind_reads(a_kind_i);
   assign a_wr = kind_writes(a_kind_i);
   assign b_rd = kind_reads(b_kind_i);
   assign b_wr = kind_writes(b_kind_i);

   assign fence_hit = fence_i
      && ((fence_pred_i[1] && a_rd) || (fence_pred_i[0] && a_wr))
      && ((fence_succ_i[1] && b_rd) || (fence_succ_i[0] && b_wr));

   always_comb begin
      raw              = '0;
      raw[RI_OVL_ST]   = b_wr && overlap_i;
      raw[RI_ATOM_FWD] = a_atomic_src_i && b_rd && b_got_a_i;
      raw[RI_LD_LD]    = a_rd && b_rd && overlap_i && ld_diff_src_i;
      raw[RI_FENCE]    = fence_hit;
      raw[RI_ACQ]      = a_aq_i;
      raw[RI_REL]      = b_rl_i;
      raw[RI_SC_BOTH]  = (a_aq_i || a_rl_i) && a_sc_ann_i
                         && (b_aq_i || b_rl_i) && b_sc_ann_i;
      raw[RI_PAIRED]   = paired_i;
      raw[RI_DEP_ADDR] = dep_addr_i;
      raw[RI_DEP_DATA] = b_wr && dep_data_i;
      raw[RI_DEP_CTRL] = b_wr && dep_ctrl_i;
      raw[RI_PIPE_FWD] = b_rd && fwd_dep_store_i;
      raw[RI_PIPE_ADR] = b_wr && mid_addr_dep_i;
   end

   assign hit_o = both_main_i ? raw : '0;

   // R1: nothing may fire for I/O pairs
   always_comb begin
      if (!both_main_i)
         p_io_silent_r1 : assert (hit_o == '0);
   end
endmodule

// File: rtl/ppo_prio.sv
module ppo_prio #(
   parameter int N      = 13,
   parameter int CODE_W = 4
) (
   input  logic [N-1:0]      hit_i,
   output logic              any_o,
   output logic [CODE_W-1:0] code_o
);
   initial begin
      assert (N < (1 << CODE_W)) else $error("CODE_W too narrow for N rules");
   end

   always_comb begin
      code_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (hit_i[i]) code_o = CODE_W'(i + 1);
      end
   end

   assign any_o = |hit_i;

   // R11: a code is reported exactly when some rule hit
   always_comb begin
      p_code_iff_hit_r11 : assert (any_o == (code_o != '0));
   end
endmodule

// File: rtl/ppo_pair_checker.sv
module ppo_pair_checker
   import ppo_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int SIZE_W    = 2,
   parameter int WIN_BYTES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid_i,
   input  logic [1:0]        a_kind_i,
   input  logic [ADDR_W-1:0] a_addr_i,
   input  logic [SIZE_W-1:0] a_size_i,
   input  logic              a_aq_i,
   input  logic              a_rl_i,
   input  logic              a_sc_ann_i,
   input  logic              a_main_i,
   input  logic              a_atomic_src_i,
   input  logic [1:0]        b_kind_i,
   input  logic [ADDR_W-1:0] b_addr_i,
   input  logic [SIZE_W-1:0] b_size_i,
   input  logic              b_aq_i,
   input  logic              b_rl_i,
   input  logic              b_sc_ann_i,
   input  logic              b_main_i,
   input  logic              fence_i,
   input  logic [1:0]        fence_pred_i,
   input  logic [1:0]        fence_succ_i,
   input  logic              paired_i,
   input  logic              dep_addr_i,
   input  logic              dep_data_i,
   input  logic              dep_ctrl_i,
   input  logic              b_got_a_i,
   input  logic              ld_diff_src_i,
   input  logic              fwd_dep_store_i,
   input  logic              mid_addr_dep_i,
   output logic              done_o,
   output logic              order_o,
   output logic [3:0]        reason_o
);
   initial begin
      assert (ADDR_W > $clog2(WIN_BYTES)) else $error("ADDR_W too small");
      assert (CODE_W == 4) else $error("reason port is 4 bits");
   end

   logic                 overlap, any_hit;
   logic [NUM_RULES-1:0] hits;
   logic [CODE_W-1:0]    code;

   ppo_overlap #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .WIN_BYTES(WIN_BYTES)) u_ovl (
      .a_addr_i (a_addr_i), .a_size_i (a_size_i),
      .b_addr_i (b_addr_i), .b_size_i (b_size_i),
      .overlap_o(overlap)
   );

   ppo_rules u_rules (
      .a_kind_i       (a_kind_i),
      .b_kind_i       (b_kind_i),
      .overlap_i      (overlap),
      .both_main_i    (a_main_i && b_main_i),
      .a_aq_i         (a_aq_i),
      .a_rl_i         (a_rl_i),
      .a_sc_ann_i     (a_sc_ann_i),
      .a_atomic_src_i (a_atomic_src_i),
      .b_aq_i         (b_aq_i),
      .b_rl_i         (b_rl_i),
      .b_sc_ann_i     (b_sc_ann_i),
      .fence_i        (fence_i),
      .fence_pred_i   (fence_pred_i),
      .fence_succ_i   (fence_succ_i),
      .paired_i       (paired_i),
      .dep_addr_i     (dep_addr_i),
      .dep_data_i     (dep_data_i),
      .dep_ctrl_i     (dep_ctrl_i),
      .b_got_a_i      (b_got_a_i),
      .ld_diff_src_i  (ld_diff_src_i),
      .fwd_dep_store_i(fwd_dep_store_i),
      .mid_addr_dep_i (mid_addr_dep_i),
      .hit_o          (hits)
   );

   ppo_prio #(.N(NUM_RULES), .CODE_W(CODE_W)) u_prio (
      .hit_i (hits),
      .any_o (any_hit),
      .code_o(code)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_o   <= 1'b0;
         order_o  <= 1'b0;
         reason_o <= '0;
      end else begin
         done_o <= valid_i;
         if (valid_i) begin
            order_o  <= any_hit;
            reason_o <= code;
         end
      end
   end

   // R1: an I/O operation on either side never yields order
   p_io_no_order_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      valid_i && !(a_main_i && b_main_i) |=> !order_o && reason_o == '0);

   // R2: a writing B at A's exact address is always ordered by overlap
   p_same_addr_store_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      valid_i && a_main_i && b_main_i && kind_writes(b_kind_i)
      && a_addr_i == b_addr_i |=> order_o && reason_o == 4'd1);

   // R7: acquire on A forces order
   p_acquire_orders_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      valid_i && a_main_i && b_main_i && a_aq_i |=> order_o);

   // R12: done pulses one cycle after valid, and results hold without valid
   p_done_after_valid_r12 : assert property (@(posedge clk) disable iff (!rst_n)
      valid_i |=> done_o);
   p_hold_when_idle_r12 : assert property (@(posedge clk) disable iff (!rst_n)
      !valid_i |=> !done_o && $stable(order_o) && $stable(reason_o));
endmodule

// File: tb/ppo_pair_checker_tb_top.sv
`timescale 1ns/1ps
module ppo_pair_checker_tb_top;
   localparam int ADDR_W = 32;
   localparam int SIZE_W = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic              valid;
   logic [1:0]        a_kind, b_kind;
   logic [ADDR_W-1:0] a_addr, b_addr;
   logic [SIZE_W-1:0] a_size, b_size;
   logic a_aq, a_rl, a_sc, a_main, a_atom;
   logic b_aq, b_rl, b_sc, b_main;
   logic fence; logic [1:0] fpred, fsucc;
   logic paired, d_addr, d_data, d_ctrl, got_a, diff_src, fwd_st, mid_ad;
   logic done, order; logic [3:0] reason;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   ppo_pair_checker #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .WIN_BYTES(8)) dut_i (
      .clk(clk), .rst_n(rst_n), .valid_i(valid),
      .a_kind_i(a_kind), .a_addr_i(a_addr), .a_size_i(a_size),
      .a_aq_i(a_aq), .a_rl_i(a_rl), .a_sc_ann_i(a_sc), .a_main_i(a_main),
      .a_atomic_src_i(a_atom),
      .b_kind_i(b_kind), .b_addr_i(b_addr), .b_size_i(b_size),
      .b_aq_i(b_aq), .b_rl_i(b_rl), .b_sc_ann_i(b_sc), .b_main_i(b_main),
      .fence_i(fence), .fence_pred_i(fpred), .fence_succ_i(fsucc),
      .paired_i(paired), .dep_addr_i(d_addr), .dep_data_i(d_data),
      .dep_ctrl_i(d_ctrl), .b_got_a_i(got_a), .ld_diff_src_i(diff_src),
      .fwd_dep_store_i(fwd_st), .mid_addr_dep_i(mid_ad),
      .done_o(done), .order_o(order), .reason_o(reason)
   );

   function automatic bit rd(input logic [1:0] k); return k == 2'b00 || k == 2'b10; endfunction
   function automatic bit wr(input logic [1:0] k); return k == 2'b01 || k == 2'b10; endfunction

   // interval-based overlap model
   function automatic bit ovl_ref();
      longint alo = a_addr, blo = b_addr;
      longint ahi = alo + (1 << a_size) - 1;
      longint bhi = blo + (1 << b_size) - 1;
      bit ax = (alo % 8) + (1 << a_size) > 8;
      bit bx = (blo % 8) + (1 << b_size) > 8;
      return ax || bx || (alo <= bhi && blo <= ahi);
   endfunction

   function automatic logic [3:0] exp_reason();
      bit ov = ovl_ref();
      if (!(a_main && b_main)) return 4'd0;
      if (wr(b_kind) && ov) return 4'd1;
      if (a_atom && rd(b_kind) && got_a) return 4'd2;
      if (rd(a_kind) && rd(b_kind) && ov && diff_src) return 4'd3;
      if (fence && ((fpred[1] && rd(a_kind)) || (fpred[0] && wr(a_kind)))
                && ((fsucc[1] && rd(b_kind)) || (fsucc[0] && wr(b_kind)))) return 4'd4;
      if (a_aq) return 4'd5;
      if (b_rl) return 4'd6;
      if ((a_aq || a_rl) && a_sc && (b_aq || b_rl) && b_sc) return 4'd7;
      if (paired) return 4'd8;
      if (d_addr) return 4'd9;
      if (wr(b_kind) && d_data) return 4'd10;
      if (wr(b_kind) && d_ctrl) return 4'd11;
      if (rd(b_kind) && fwd_st) return 4'd12;
      if (wr(b_kind) && mid_ad) return 4'd13;
      return 4'd0;
   endfunction

   function automatic string req_of(input logic [3:0] r);
      case (r)
         4'd0: return "R1/R11";  4'd1: return "R2";  4'd2: return "R4";
         4'd3: return "R5";      4'd4: return "R6";  4'd5, 4'd6: return "R7";
         4'd7, 4'd8: return "R8"; 4'd9, 4'd10, 4'd11: return "R9";
         default: return "R10";
      endcase
   endfunction

   task automatic check(input string req, input logic [5:0] got, input logic [5:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got done/order/reason=%b expected %b", req, got, exp);
      end
   endtask

   task automatic defaults();
      valid = 0; a_kind = 2'b00; b_kind = 2'b00;
      a_addr = 32'h100; b_addr = 32'h200; a_size = 0; b_size = 0;
      a_aq = 0; a_rl = 0; a_sc = 0; a_main = 1; a_atom = 0;
      b_aq = 0; b_rl = 0; b_sc = 0; b_main = 1;
      fence = 0; fpred = 0; fsucc = 0; paired = 0;
      d_addr = 0; d_data = 0; d_ctrl = 0; got_a = 0; diff_src = 0; fwd_st = 0; mid_ad = 0;
   endtask

   // drive at a falling edge, result sampled at the next falling edge
   task automatic run(input string req);
      logic [3:0] e = exp_reason();
      string tag = (req == "") ? req_of(e) : req;
      valid = 1;
      @(negedge clk);
      check(tag, {1'b1, order, reason}, {1'b1, e != 4'd0, e});
      defaults();
   endtask

   initial begin
      #(4 * 100000);
      if (!finished) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [3:0] keep;
      void'($urandom(32'd7731));
      defaults();
      repeat (3) @(negedge clk);
      check("R12 reset", {done, order, reason}, 6'b0);
      rst_n = 1;
      @(negedge clk);

      a_main = 0; a_aq = 1; b_kind = 2'b01; b_addr = a_addr; run("R1 io");
      b_kind = 2'b01; a_size = 2; b_addr = a_addr + 2; run("R2 partial");
      b_kind = 2'b01; a_size = 1; b_addr = a_addr + 2; run("R2 adjacent");
      b_kind = 2'b10; b_addr = 32'h108; a_size = 3; run("R2 next window");
      b_kind = 2'b01; a_addr = 32'h106; a_size = 2; b_addr = 32'h400; run("R3 cross");
      a_kind = 2'b01; a_atom = 1; got_a = 1; run("R4");
      b_addr = a_addr; b_size = 1; diff_src = 1; run("R5 overlap");
      diff_src = 1; run("R5 disjoint");
      a_kind = 2'b01; fence = 1; fpred = 2'b01; fsucc = 2'b10; run("R6 hit");
      a_kind = 2'b01; fence = 1; fpred = 2'b10; fsucc = 2'b10; run("R6 miss");
      a_aq = 1; run("R7 acquire");
      b_rl = 1; run("R7 release");
      a_rl = 1; a_sc = 1; b_aq = 1; b_sc = 1; run("R8 sc both");
      a_rl = 1; a_sc = 1; b_aq = 1; run("R8 one side");
      paired = 1; run("R8 paired");
      d_addr = 1; run("R9 addr");
      b_kind = 2'b01; d_data = 1; run("R9 data");
      d_data = 1; d_ctrl = 1; run("R9 load ignores");
      b_kind = 2'b01; d_ctrl = 1; run("R9 ctrl");
      fwd_st = 1; run("R10 fwd");
      b_kind = 2'b01; mid_ad = 1; run("R10 mid");
      b_kind = 2'b01; b_addr = a_addr; a_aq = 1; d_addr = 1; run("R11 priority");
      a_aq = 1; b_rl = 1; paired = 1; run("R11 acquire first");

      keep = reason;
      @(negedge clk);
      check("R12 hold", {done, order, reason}, {1'b0, 1'b1, keep});

      for (int n = 0; n < 600; n++) begin
         a_kind = 2'($urandom_range(0, 2)); b_kind = 2'($urandom_range(0, 2));
         a_addr = 32'h100 + $urandom_range(0, 23); b_addr = 32'h100 + $urandom_range(0, 23);
         a_size = 2'($urandom_range(0, 3)); b_size = 2'($urandom_range(0, 3));
         a_main = ($urandom_range(0, 9) != 0); b_main = ($urandom_range(0, 9) != 0);
         a_aq = ($urandom_range(0, 7) == 0); a_rl = ($urandom_range(0, 7) == 0);
         a_sc = $urandom_range(0, 1); a_atom = ($urandom_range(0, 3) == 0);
         b_aq = ($urandom_range(0, 7) == 0); b_rl = ($urandom_range(0, 7) == 0);
         b_sc = $urandom_range(0, 1);
         fence = ($urandom_range(0, 5) == 0);
         fpred = 2'($urandom_range(0, 3)); fsucc = 2'($urandom_range(0, 3));
         paired = ($urandom_range(0, 9) == 0); d_addr = ($urandom_range(0, 7) == 0);
         d_data = ($urandom_range(0, 5) == 0); d_ctrl = ($urandom_range(0, 5) == 0);
         got_a = ($urandom_range(0, 4) == 0); diff_src = ($urandom_range(0, 2) == 0);
         fwd_st = ($urandom_range(0, 5) == 0); mid_ad = ($urandom_range(0, 5) == 0);
         run("");
      end

      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule